// File: doc/BRIEF.md
# Framed Command Register Writer

This block sits behind a byte-wide serial receiver (8 data bits, 1 stop bit, no parity, 115200 baud). It turns the incoming bytes into fixed eight-byte command frames and commits each well-formed frame as a single register write. A frame opens with the marker byte 0xAA and closes with the marker byte 0xBB. Between them come an 8-bit target address, four bits that carry no meaning and a 36-bit signed fixed-point value: one sign bit, 26 integer bits and 9 fraction bits. In that format the value 0x500 stands for 2.5.

Three addresses load the three controller gains: proportional, derivative and integral. Two further addresses raise or drop a global reset flag. Any other address is accepted and then ignored. When the closing marker is wrong, the frame is thrown away and a one-cycle error pulse is raised. When the line goes quiet in the middle of a frame, the partial frame is abandoned once a programmable idle limit is reached.

Bytes enter on a valid/ready stream. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. The sender must hold `in_valid` and `in_data` steady until that edge. `in_ready` drops for exactly one cycle after the eighth byte of a frame is taken, while that frame is committed. In every other cycle it is high.

Top module: `frame_reg_writer`

## Requirements
- R1: After reset, all three gain outputs are zero, `rst_flag_o` is 0, `frame_err_o` is 0 and `in_ready` is 1.
- R2: A frame with closing marker 0xBB loads its 36-bit value into one gain output. Address 0x01 selects `kp_o`, address 0x02 selects `kd_o` and address 0x03 selects `ki_o`. The other two gains keep their values.
- R3: A valid frame with address 0x00 sets `rst_flag_o` to 1, and one with address 0x0D clears it to 0. Neither changes a gain.
- R4: While the block is hunting for a frame, every byte other than 0xAA is discarded and has no effect on any output.
- R5: A frame whose eighth byte is not 0xBB changes no output register and raises `frame_err_o` for exactly one cycle.
- R6: A valid frame whose address is none of 0x00, 0x01, 0x02, 0x03 or 0x0D changes no output and raises no error.
- R7: If no byte is accepted for TIMEOUT_CYCLES consecutive cycles in the middle of a frame, the partial frame is dropped and the block goes back to hunting for 0xAA.
- R8: After the eighth byte is accepted, `in_ready` is 0 for exactly one cycle. The output registers and `frame_err_o` change at the clock edge that ends that cycle, and at no other time.
- R9: The frame layout, most significant byte first, is [63:56] 0xAA, [55:48] address, [47:44] ignored bits, [43:8] value, [7:0] 0xBB. The ignored bits never affect the result, and a negative value is stored with all 36 bits intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received byte is present on `in_data` |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Received byte |
| kp_o | output | 36 | Proportional gain, signed fixed point 1.26.9 |
| kd_o | output | 36 | Derivative gain, signed fixed point 1.26.9 |
| ki_o | output | 36 | Integral gain, signed fixed point 1.26.9 |
| rst_flag_o | output | 1 | Global reset flag set and cleared by command |
| frame_err_o | output | 1 | One-cycle pulse when a frame's closing marker is wrong |

## Verification
Each gain address is written in turn with a different value. Checking the two gains that were not addressed shows whether the address decode selects one target or several. A negative value sent with all ignored bits set separates correct field slicing from an off-by-nibble extraction. Garbage bytes sent before an opening marker, and a frame with a bad closing marker, each show whether the hunt logic and the end check are really in force. An unknown address tells a silent ignore apart from an error. A partial frame followed by a long silence and then a complete frame shows whether the idle limit realigns the framing; without the timeout, that sequence would end in a frame error. Stepping the last byte one cycle at a time exposes the single commit cycle in which `in_ready` is low.

// File: rtl/frmw_pkg.sv
package frmw_pkg;

  localparam logic [7:0] SOF_BYTE = 8'hAA;
  localparam logic [7:0] EOF_BYTE = 8'hBB;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_BODY   = 2'd1,
    ST_COMMIT = 2'd2
  } rx_state_t;

  // Write target; gain slots are numbered 1..N in the same order as gain_bank.
  typedef enum logic [2:0] {
    TGT_NONE    = 3'd0,
    TGT_KP      = 3'd1,
    TGT_KD      = 3'd2,
    TGT_KI      = 3'd3,
    TGT_RST_SET = 3'd4,
    TGT_RST_CLR = 3'd5
  } tgt_t;

endpackage

// File: rtl/frame_shifter.sv
module frame_shifter
  import frmw_pkg::*;
#(
  parameter int FRAME_BYTES    = 8,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  output logic                      in_ready,
  output logic                      frame_valid,
  output logic [FRAME_BYTES*8-1:0]  frame_bits
);

  localparam int FRAME_W = FRAME_BYTES * 8;
  localparam int CNT_W   = $clog2(FRAME_BYTES + 1);
  localparam int IDLE_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(FRAME_BYTES - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT_CYCLES - 1);

  rx_state_t             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [IDLE_W-1:0]     idle_q;
  logic [FRAME_W-1:0]    shreg_q;
  logic                  accept;

  assign in_ready    = (state_q != ST_COMMIT);
  assign accept      = in_valid && in_ready;
  assign frame_valid = (state_q == ST_COMMIT);
  assign frame_bits  = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      idle_q  <= '0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          idle_q <= '0;
          if (accept && (in_data == SOF_BYTE)) begin
            shreg_q <= {shreg_q[FRAME_W-9:0], in_data};
            cnt_q   <= CNT_W'(1);
            state_q <= ST_BODY;
          end
        end
        ST_BODY: begin
          if (accept) begin
            shreg_q <= {shreg_q[FRAME_W-9:0], in_data};
            idle_q  <= '0;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (cnt_q == LAST_IDX) begin
              state_q <= ST_COMMIT;
            end
          end else if (idle_q == IDLE_MAX) begin
            idle_q  <= '0;
            cnt_q   <= '0;
            state_q <= ST_HUNT;
          end else begin
            idle_q <= idle_q + IDLE_W'(1);
          end
        end
        ST_COMMIT: begin
          cnt_q   <= '0;
          state_q <= ST_HUNT;
        end
        default: begin
          cnt_q   <= '0;
          state_q <= ST_HUNT;
        end
      endcase
    end
  end

endmodule

// File: rtl/frame_check.sv
module frame_check
  import frmw_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int ADDR_W      = 8,
  parameter int PAD_W       = 4,
  parameter int DATA_W      = 36,
  parameter logic [7:0] ADDR_RST_SET = 8'h00,
  parameter logic [7:0] ADDR_KP      = 8'h01,
  parameter logic [7:0] ADDR_KD      = 8'h02,
  parameter logic [7:0] ADDR_KI      = 8'h03,
  parameter logic [7:0] ADDR_RST_CLR = 8'h0D
) (
  input  logic                      frame_valid,
  input  logic [FRAME_BYTES*8-1:0]  frame_bits,
  output logic                      commit,
  output logic                      bad_eof,
  output tgt_t                      target,
  output logic [DATA_W-1:0]         value
);

  localparam int DATA_LSB = 8;
  localparam int PAD_LSB  = DATA_LSB + DATA_W;
  localparam int ADDR_LSB = PAD_LSB + PAD_W;

  logic [ADDR_W-1:0] addr;
  logic              eof_ok;

  assign eof_ok  = (frame_bits[7:0] == EOF_BYTE);
  assign addr    = frame_bits[ADDR_LSB +: ADDR_W];
  assign value   = frame_bits[DATA_LSB +: DATA_W];
  assign commit  = frame_valid && eof_ok;
  assign bad_eof = frame_valid && !eof_ok;

  always_comb begin
    if (addr == ADDR_W'(ADDR_KP))           target = TGT_KP;
    else if (addr == ADDR_W'(ADDR_KD))      target = TGT_KD;
    else if (addr == ADDR_W'(ADDR_KI))      target = TGT_KI;
    else if (addr == ADDR_W'(ADDR_RST_SET)) target = TGT_RST_SET;
    else if (addr == ADDR_W'(ADDR_RST_CLR)) target = TGT_RST_CLR;
    else                                    target = TGT_NONE;
  end

endmodule

// File: rtl/gain_bank.sv
module gain_bank
  import frmw_pkg::*;
#(
  parameter int   DATA_W        = 36,
  parameter int   N_GAIN        = 3,
  parameter logic RST_FLAG_INIT = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic                          bad_eof,
  input  tgt_t                          target,
  input  logic [DATA_W-1:0]             value,
  output logic [N_GAIN-1:0][DATA_W-1:0] gains,
  output logic                          rst_flag,
  output logic                          frame_err
);

  for (genvar g = 0; g < N_GAIN; g++) begin : g_gain
    logic hit;
    assign hit = commit && (target == tgt_t'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   gains[g] <= '0;
      else if (hit) gains[g] <= value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_flag  <= RST_FLAG_INIT;
      frame_err <= 1'b0;
    end else begin
      frame_err <= bad_eof;
      if (commit && target == TGT_RST_SET)      rst_flag <= 1'b1;
      else if (commit && target == TGT_RST_CLR) rst_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_reg_writer.sv
module frame_reg_writer
  import frmw_pkg::*;
#(
  parameter int FRAME_BYTES    = 8,
  parameter int DATA_W         = 36,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic [DATA_W-1:0] kp_o,
  output logic [DATA_W-1:0] kd_o,
  output logic [DATA_W-1:0] ki_o,
  output logic              rst_flag_o,
  output logic              frame_err_o
);

  localparam int FRAME_W = FRAME_BYTES * 8;
  localparam int N_GAIN  = 3;

  logic                          frame_valid;
  logic [FRAME_W-1:0]            frame_bits;
  logic                          commit;
  logic                          bad_eof;
  tgt_t                          target;
  logic [DATA_W-1:0]             value;
  logic [N_GAIN-1:0][DATA_W-1:0] gains;

  frame_shifter #(
    .FRAME_BYTES   (FRAME_BYTES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .frame_valid(frame_valid),
    .frame_bits (frame_bits)
  );

  frame_check #(
    .FRAME_BYTES(FRAME_BYTES),
    .DATA_W     (DATA_W)
  ) u_check (
    .frame_valid(frame_valid),
    .frame_bits (frame_bits),
    .commit     (commit),
    .bad_eof    (bad_eof),
    .target     (target),
    .value      (value)
  );

  gain_bank #(
    .DATA_W(DATA_W),
    .N_GAIN(N_GAIN)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .bad_eof  (bad_eof),
    .target   (target),
    .value    (value),
    .gains    (gains),
    .rst_flag (rst_flag_o),
    .frame_err(frame_err_o)
  );

  assign kp_o = gains[0];
  assign kd_o = gains[1];
  assign ki_o = gains[2];

endmodule

// File: rtl/frame_reg_writer_chk.sv
module frame_reg_writer_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [DATA_W-1:0] kp_o,
  input logic [DATA_W-1:0] kd_o,
  input logic [DATA_W-1:0] ki_o,
  input logic              rst_flag_o,
  input logic              frame_err_o
);

  AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o); // R5

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> ($stable(kp_o) && $stable(kd_o) && $stable(ki_o) && $stable(rst_flag_o))); // R5

  AST_READY_ONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready); // R8

  AST_GAINS_HOLD_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ($stable(kp_o) && $stable(kd_o) && $stable(ki_o))); // R8

  AST_FLAG_HOLD_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $stable(rst_flag_o)); // R3

  AST_ERR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !frame_err_o); // R8

endmodule

bind frame_reg_writer frame_reg_writer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .kp_o       (kp_o),
  .kd_o       (kd_o),
  .ki_o       (ki_o),
  .rst_flag_o (rst_flag_o),
  .frame_err_o(frame_err_o)
);

// File: tb/frame_reg_writer_bench.sv
`timescale 1ns/1ps
module frame_reg_writer_bench;

  localparam int DW = 36;
  localparam int TO = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic [DW-1:0] kp_o, kd_o, ki_o;
  logic          rst_flag_o, frame_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  frame_reg_writer #(.TIMEOUT_CYCLES(TO)) u_frame_reg_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .kp_o(kp_o), .kd_o(kd_o), .ki_o(ki_o),
    .rst_flag_o(rst_flag_o), .frame_err_o(frame_err_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] mk(input logic [7:0] a, input logic [3:0] pad,
                                     input logic [DW-1:0] d, input logic [7:0] eof);
    return {8'hAA, a, pad, d, eof};
  endfunction

  // Sends all eight bytes, then waits until the commit edge has passed.
  task automatic send_frame(input logic [63:0] f);
    for (int i = 7; i >= 0; i--) send_byte(f[i*8 +: 8]);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 kp", kp_o, '0);
    chk("R1 kd", kd_o, '0);
    chk("R1 ki", ki_o, '0);
    chk("R1 flag", DW'(rst_flag_o), '0);
    chk("R1 err", DW'(frame_err_o), '0);
    chk("R1 ready", DW'(in_ready), DW'(1));
  endtask

  task automatic t_gains;
    send_frame(mk(8'h01, 4'h0, 36'h500, 8'hBB));
    chk("R2 kp=2.5", kp_o, 36'h500);
    chk("R2 kd untouched", kd_o, '0);
    chk("R2 ki untouched", ki_o, '0);
    send_frame(mk(8'h02, 4'h0, 36'h0_1234_5678, 8'hBB));
    chk("R2 kd", kd_o, 36'h0_1234_5678);
    chk("R2 kp kept", kp_o, 36'h500);
    send_frame(mk(8'h03, 4'h0, 36'h7_0000_0001, 8'hBB));
    chk("R2 ki", ki_o, 36'h7_0000_0001);
    chk("R2 kd kept", kd_o, 36'h0_1234_5678);
  endtask

  task automatic t_flag;
    send_frame(mk(8'h00, 4'h0, 36'h0, 8'hBB));
    chk("R3 flag set", DW'(rst_flag_o), DW'(1));
    chk("R3 kp kept", kp_o, 36'h500);
    send_frame(mk(8'h0D, 4'h0, 36'h0_0000_FFFF, 8'hBB));
    chk("R3 flag clear", DW'(rst_flag_o), '0);
    chk("R3 ki kept", ki_o, 36'h7_0000_0001);
  endtask

  task automatic t_hunt;
    send_byte(8'h12);
    send_byte(8'hBB);
    send_byte(8'h03);
    send_frame(mk(8'h03, 4'h0, 36'h7, 8'hBB));
    chk("R4 ki after garbage", ki_o, 36'h7);
    chk("R4 no err", DW'(frame_err_o), '0);
  endtask

  task automatic t_bad_eof;
    send_frame(mk(8'h01, 4'h0, 36'h999, 8'hBC));
    chk("R5 err pulse", DW'(frame_err_o), DW'(1));
    chk("R5 kp kept", kp_o, 36'h500);
    @(negedge clk);
    chk("R5 err one cycle", DW'(frame_err_o), '0);
  endtask

  task automatic t_unknown;
    send_frame(mk(8'h07, 4'h0, 36'h123, 8'hBB));
    chk("R6 no err", DW'(frame_err_o), '0);
    chk("R6 kp kept", kp_o, 36'h500);
    chk("R6 kd kept", kd_o, 36'h0_1234_5678);
    chk("R6 ki kept", ki_o, 36'h7);
    chk("R6 flag kept", DW'(rst_flag_o), '0);
  endtask

  task automatic t_timeout;
    send_byte(8'hAA);
    send_byte(8'h01);
    send_byte(8'h00);
    repeat (TO + 50) @(negedge clk);
    send_frame(mk(8'h02, 4'h0, 36'h0_0000_0A00, 8'hBB));
    chk("R7 kd after timeout", kd_o, 36'h0_0000_0A00);
    chk("R7 no err", DW'(frame_err_o), '0);
  endtask

  task automatic t_commit_timing;
    logic [63:0] f;
    f = mk(8'h01, 4'h0, 36'h0_0000_0C00, 8'hBB);
    for (int i = 7; i >= 1; i--) send_byte(f[i*8 +: 8]);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = f[7:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 ready low in commit", DW'(in_ready), '0);
    chk("R8 kp not yet", kp_o, 36'h500);
    @(negedge clk);
    chk("R8 ready back", DW'(in_ready), DW'(1));
    chk("R8 kp updated", kp_o, 36'h0_0000_0C00);
  endtask

  task automatic t_negative;
    send_frame(mk(8'h01, 4'hF, 36'hF_FFFF_FE00, 8'hBB));
    chk("R9 negative kp", kp_o, 36'hF_FFFF_FE00);
    send_frame(mk(8'h03, 4'hA, 36'h8_0000_0000, 8'hBB));
    chk("R9 pad ignored ki", ki_o, 36'h8_0000_0000);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gains();
    t_flag();
    t_hunt();
    t_bad_eof();
    t_unknown();
    t_timeout();
    t_commit_timing();
    t_negative();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

endmodule